// File: doc/BRIEF.md
# Column-Parallel Cluster Finder and Sparsifier

This block sits behind a column-parallel sensor readout. Every accepted clock brings one whole row of 5-bit pixel codes, one per column. It slides a 2x2 window over each pair of adjacent rows, across all columns at once. Each window sum is compared with one global threshold. Around every window that fires, a square neighbourhood of pixels is marked. Only the marked pixels leave the block, one word per pixel, carrying row, column and value. They pass through an output FIFO with a valid/ready handshake.

The controller is a three-state machine. In `ST_IDLE` it waits for a frame start. The transition IDLE->RUN clears the row counter and the window buffers. In `ST_RUN` each row strobe shifts one row into the window. After the last row of the frame, the transition RUN->FLUSH occurs. In `ST_FLUSH` the machine pushes empty virtual rows until the bottom rows have been emitted. Each push waits until the previous row has drained. After the last push the transition FLUSH->IDLE occurs. Rows are delivered with no back-pressure. Words that find no room are therefore lost, and a sticky overflow flag records the loss.

Top module: `colpar_sparsifier`

## Requirements
- R1: While reset is held and in the cycle after it, `out_valid` and `overflow` are 0.
- R2: A window anchored at row r, column c covers pixels (r,c), (r,c+1), (r+1,c) and (r+1,c+1). It fires only when the sum of the four codes is strictly greater than `threshold`. A sum equal to the threshold flags nothing.
- R3: A firing window at anchor (r,c) marks every pixel with row in r-3..r+3 and column in c-3..c+3. The radius is 3 with the default `RAD`. Coordinates outside the array are dropped, so fewer words come out at the edges.
- R4: Overlapping marked regions merge. Each pixel of a frame is emitted at most once.
- R5: Rows are emitted in ascending order. Within a row, columns are emitted in ascending order.
- R6: `out_data` is {row, column, value}. The row index is in the top RW bits, the column index in the next CW bits, and the 5-bit code in the low bits.
- R7: A frame begins only with `frame_start` in `ST_IDLE` and takes exactly NROW row strobes. Row strobes outside a frame have no effect and produce no output.
- R8: A word that meets a full FIFO is discarded and sets `overflow`. `overflow` then stays 1 until reset.
- R9: If a new row becomes ready while marked words of the previous row are still waiting, those remaining words are discarded and `overflow` is set.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Opens a frame when the block is idle |
| row_valid | input | 1 | One row of samples is present on `row_data` |
| row_data | input | NCOL*DW | Row samples, column c at bits c*DW +: DW |
| threshold | input | DW+2 | Global window-sum threshold |
| out_valid | output | 1 | FIFO holds a word |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | RW+CW+DW | {row, column, value} |
| overflow | output | 1 | Sticky loss indicator |

## Verification
The bench builds the block with 16 columns, 10 rows and an 8-entry FIFO. With so few columns, a window placed near any corner reaches the clipping on both axes and the bottom-row flush within a short frame. The shallow FIFO can be filled by a single 49-pixel region while the consumer stalls. Feeding rows with no gap makes the discard of a partly drained row happen at a cycle that can be predicted exactly.

// File: rtl/csp_pkg.sv
package csp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } csp_state_e;
endpackage

// File: rtl/csp_kernel.sv
module csp_kernel #(
    parameter int NCOL = 125,
    parameter int DW   = 5,
    parameter int SW   = 7,
    parameter int RAD  = 3
) (
    input  logic                     en,
    input  logic [NCOL-1:0][DW-1:0]  row_a,
    input  logic [NCOL-1:0][DW-1:0]  row_b,
    input  logic [SW-1:0]            thr,
    output logic [NCOL-1:0]          dil
);
    logic [NCOL-1:0] hit;

    // Window sums, one per anchor column; the last column anchors nothing.
    for (genvar c = 0; c < NCOL; c++) begin : g_win
        if (c < NCOL - 1) begin : g_sum
            logic [SW-1:0] sum;
            assign sum = SW'(row_a[c]) + SW'(row_a[c+1])
                       + SW'(row_b[c]) + SW'(row_b[c+1]);
            assign hit[c] = en && (sum > thr);
        end else begin : g_last
            assign hit[c] = 1'b0;
        end
    end

    // Horizontal spread of each hit by RAD columns, clipped at the edges.
    always_comb begin
        dil = '0;
        for (int c = 0; c < NCOL; c++) begin
            for (int d = -RAD; d <= RAD; d++) begin
                if (c + d >= 0 && c + d < NCOL) begin
                    dil[c] = dil[c] | hit[c+d];
                end
            end
        end
    end
endmodule

// File: rtl/csp_drain.sv
module csp_drain #(
    parameter int NCOL = 125,
    parameter int DW   = 5,
    parameter int RW   = 7,
    parameter int CW   = 7,
    localparam int OW  = RW + CW + DW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [NCOL-1:0]          ld_mask,
    input  logic [NCOL-1:0][DW-1:0]  ld_data,
    input  logic [RW-1:0]            ld_row,
    output logic                     wr_req,
    output logic [OW-1:0]            wr_word,
    output logic                     idle,
    output logic                     lost
);
    logic [NCOL-1:0]         mask;
    logic [NCOL-1:0]         pick;
    logic [NCOL-1:0][DW-1:0] data;
    logic [RW-1:0]           row;
    logic [CW-1:0]           idx;

    // Lowest marked column first.
    always_comb begin
        idx = '0;
        for (int i = NCOL - 1; i >= 0; i--) begin
            if (mask[i]) idx = CW'(i);
        end
    end

    assign pick    = {{(NCOL-1){1'b0}}, 1'b1} << idx;
    assign wr_req  = |mask;
    assign idle    = ~|mask;
    assign lost    = load && |(mask & ~pick);
    assign wr_word = {row, idx, data[idx]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (load) begin
            mask <= ld_mask;
        end else begin
            mask <= mask & ~pick;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            data <= ld_data;
            row  <= ld_row;
        end
    end
endmodule

// File: rtl/csp_fifo.sv
module csp_fifo #(
    parameter int W     = 19,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wd,
    output logic         full,
    input  logic         re,
    output logic         valid,
    output logic [W-1:0] rd
);
    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          push, pop;

    assign full  = (cnt == (AW+1)'(DEPTH));
    assign valid = (cnt != '0);
    assign rd    = mem[rp];
    assign push  = we && !full;
    assign pop   = re && valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wd;
    end
endmodule

// File: rtl/colpar_sparsifier.sv
module colpar_sparsifier
    import csp_pkg::*;
#(
    parameter int NCOL       = 125,
    parameter int NROW       = 128,
    parameter int DW         = 5,
    parameter int RAD        = 3,
    parameter int FIFO_DEPTH = 64,
    localparam int SW  = DW + 2,
    localparam int RW  = $clog2(NROW),
    localparam int CW  = $clog2(NCOL),
    localparam int OW  = RW + CW + DW,
    localparam int KW  = $clog2(NROW + RAD + 2),
    localparam int NWIN = 2 * RAD + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 row_valid,
    input  logic [NCOL*DW-1:0]   row_data,
    input  logic [SW-1:0]        threshold,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [OW-1:0]        out_data,
    output logic                 overflow
);
    csp_state_e st, st_n;

    logic [NCOL-1:0][DW-1:0]        row_in;
    logic [NCOL-1:0][DW-1:0]        fresh;
    logic [KW-1:0]                  rcnt;
    logic [NWIN-1:0][NCOL-1:0]      flg;      // slot j: row rcnt-(RAD+1)+j
    logic [RAD:0][NCOL-1:0][DW-1:0] hist;     // slot j: row rcnt-(RAD+1)+j
    logic [NCOL-1:0]                dil;
    logic                           step, kern_en, emit, frame_go;
    logic                           drain_idle, drain_req, drain_lost;
    logic [OW-1:0]                  drain_word;
    logic                           fifo_full;

    assign row_in = row_data;

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_n;
    end

    // Next state and control outputs
    always_comb begin
        st_n     = st;
        step     = 1'b0;
        frame_go = 1'b0;
        unique case (st)
            ST_IDLE: begin
                frame_go = frame_start;
                if (frame_start) st_n = ST_RUN;
            end
            ST_RUN: begin
                step = row_valid;
                if (row_valid && rcnt == KW'(NROW - 1)) st_n = ST_FLUSH;
            end
            ST_FLUSH: begin
                step = drain_idle;
                if (drain_idle && rcnt == KW'(NROW + RAD)) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
        kern_en = (st == ST_RUN) && row_valid && (rcnt != '0);
        emit    = step && (rcnt >= KW'(RAD + 1));
        fresh   = (st == ST_RUN) ? row_in : '0;
    end

    // Row window: mark accumulation and sample history
    always_ff @(posedge clk) begin
        if (rst || frame_go) begin
            rcnt <= '0;
            flg  <= '0;
            hist <= '0;
        end else if (step) begin
            rcnt <= rcnt + 1'b1;
            for (int j = 0; j < NWIN - 1; j++) flg[j] <= flg[j+1] | dil;
            flg[NWIN-1] <= '0;
            for (int j = 0; j < RAD; j++) hist[j] <= hist[j+1];
            hist[RAD] <= fresh;
        end
    end

    csp_kernel #(.NCOL(NCOL), .DW(DW), .SW(SW), .RAD(RAD)) u_kernel (
        .en    (kern_en),
        .row_a (hist[RAD]),
        .row_b (row_in),
        .thr   (threshold),
        .dil   (dil)
    );

    csp_drain #(.NCOL(NCOL), .DW(DW), .RW(RW), .CW(CW)) u_drain (
        .clk     (clk),
        .rst     (rst),
        .load    (emit),
        .ld_mask (flg[0] | dil),
        .ld_data (hist[0]),
        .ld_row  (RW'(rcnt - KW'(RAD + 1))),
        .wr_req  (drain_req),
        .wr_word (drain_word),
        .idle    (drain_idle),
        .lost    (drain_lost)
    );

    csp_fifo #(.W(OW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .we    (drain_req),
        .wd    (drain_word),
        .full  (fifo_full),
        .re    (out_ready),
        .valid (out_valid),
        .rd    (out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) overflow <= 1'b0;
        else if ((drain_req && fifo_full) || drain_lost) overflow <= 1'b1;
    end
endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
    parameter int OW = 19,
    parameter int RW = 7,
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          out_valid,
    input logic          out_ready,
    input logic [OW-1:0] out_data,
    input logic          overflow,
    input logic          row_load,
    input logic          fifo_push,
    input logic [RW-1:0] push_row,
    input logic [CW-1:0] push_col
);
    logic          seen;
    logic [RW-1:0] last_row;
    logic [CW-1:0] last_col;

    always_ff @(posedge clk) begin
        if (rst || row_load) begin
            seen <= 1'b0;
        end else if (fifo_push) begin
            seen     <= 1'b1;
            last_row <= push_row;
            last_col <= push_col;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid && !overflow); // R1
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst) out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow); // R8
    AST_COL_ASCEND: assert property (@(posedge clk) disable iff (rst) fifo_push && seen && push_row == last_row |-> push_col > last_col); // R5
endmodule

bind colpar_sparsifier csp_checker #(.OW(OW), .RW(RW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .overflow  (overflow),
    .row_load  (emit),
    .fifo_push (drain_req && !fifo_full),
    .push_row  (drain_word[OW-1 -: RW]),
    .push_col  (drain_word[DW +: CW])
);

// File: tb/tb_colpar_sparsifier.sv
module tb_colpar_sparsifier;
    localparam int NCOL = 16;
    localparam int NROW = 10;
    localparam int DW   = 5;
    localparam int RAD  = 3;
    localparam int DEP  = 8;
    localparam int RW   = 4;
    localparam int CW   = 4;
    localparam int OW   = RW + CW + DW;
    localparam int GAP  = 20;

    // {row0, col0, value, row1 (-1 = none), col1, threshold}
    localparam int VEC [6][6] = '{
        '{4, 6, 8, -1, 0, 30},
        '{0, 0, 10, -1, 0, 20},
        '{8, 14, 10, -1, 0, 20},
        '{4, 6, 5, -1, 0, 20},
        '{3, 3, 9, 5, 6, 30},
        '{4, 6, 31, -1, 0, 123}
    };

    logic clk = 1'b0, rst = 1'b1, frame_start = 1'b0, row_valid = 1'b0, out_ready = 1'b1;
    logic [NCOL*DW-1:0] row_data = '0;
    logic [DW+1:0]      threshold = '0;
    logic               out_valid, overflow;
    logic [OW-1:0]      out_data;

    int n_run = 0, n_fail = 0, n_got = 0, n_exp = 0;
    bit done = 1'b0;
    logic [DW-1:0] pix [NROW][NCOL];
    logic [OW-1:0] got [512];
    logic [OW-1:0] exp_w [512];

    colpar_sparsifier #(.NCOL(NCOL), .NROW(NROW), .DW(DW), .RAD(RAD), .FIFO_DEPTH(DEP)) dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .row_valid(row_valid),
        .row_data(row_data), .threshold(threshold), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .overflow(overflow)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (n_got < 512) got[n_got] = out_data;
            n_got++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic clear_pix();
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++) pix[r][c] = '0;
    endtask

    task automatic blob(input int r, input int c, input int v);
        pix[r][c] = DW'(v);     pix[r][c+1] = DW'(v);
        pix[r+1][c] = DW'(v);   pix[r+1][c+1] = DW'(v);
    endtask

    // Model of R2..R6: independent brute-force search
    task automatic build_expect(input int thr);
        n_exp = 0;
        for (int r = 0; r < NROW; r++) begin
            for (int c = 0; c < NCOL; c++) begin
                bit mark = 1'b0;
                for (int kr = 0; kr < NROW - 1; kr++) begin
                    for (int kc = 0; kc < NCOL - 1; kc++) begin
                        int s = int'(pix[kr][kc]) + int'(pix[kr][kc+1])
                              + int'(pix[kr+1][kc]) + int'(pix[kr+1][kc+1]);
                        if (s > thr && r - kr <= RAD && kr - r <= RAD
                            && c - kc <= RAD && kc - c <= RAD) mark = 1'b1;
                    end
                end
                if (mark) begin
                    exp_w[n_exp] = {RW'(r), CW'(c), pix[r][c]};
                    n_exp++;
                end
            end
        end
    endtask

    task automatic send_frame(input int gap, input bit with_start);
        n_got = 0;
        @(posedge clk); #1;
        if (with_start) begin
            frame_start = 1'b1;
            @(posedge clk); #1;
            frame_start = 1'b0;
        end
        for (int r = 0; r < NROW; r++) begin
            for (int c = 0; c < NCOL; c++) row_data[c*DW +: DW] = pix[r][c];
            row_valid = 1'b1;
            @(posedge clk); #1;
            row_valid = 1'b0;
            if (gap > 0) begin
                repeat (gap) @(posedge clk);
                #1;
            end
        end
        repeat (300) @(posedge clk);
        #1;
    endtask

    task automatic compare_words(input string tag, input int upto);
        int bad = 0, first_a = 0, first_e = 0;
        for (int i = 0; i < upto; i++) begin
            if (got[i] !== exp_w[i]) begin
                if (bad == 0) begin first_a = int'(got[i]); first_e = int'(exp_w[i]); end
                bad++;
            end
        end
        check(bad == 0, tag, first_a, first_e);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(out_valid == 1'b0 && overflow == 1'b0, "R1 after reset", int'({out_valid, overflow}), 0);

        // R7: rows outside a frame are ignored
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++) pix[r][c] = 5'd31;
        threshold = '0;
        send_frame(2, 1'b0);
        check(n_got == 0, "R7 rows without frame_start", n_got, 0);

        // Table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < 6; v++) begin
            clear_pix();
            blob(VEC[v][0], VEC[v][1], VEC[v][2]);
            if (VEC[v][3] >= 0) blob(VEC[v][3], VEC[v][4], VEC[v][2]);
            threshold = (DW+2)'(VEC[v][5]);
            build_expect(VEC[v][5]);
            send_frame(GAP, 1'b1);
            check(n_got == n_exp, "R2/R3/R4 word count", n_got, n_exp);
            if (n_got == n_exp) compare_words("R5/R6 word order and content", n_exp);
            check(overflow == 1'b0, "R8 no loss with free FIFO", int'(overflow), 0);
        end

        // R8: stalled consumer, FIFO fills
        clear_pix();
        blob(4, 6, 8);
        threshold = 7'd30;
        build_expect(30);
        out_ready = 1'b0;
        send_frame(GAP, 1'b1);
        check(overflow == 1'b1, "R8 overflow on full FIFO", int'(overflow), 1);
        n_got = 0;
        out_ready = 1'b1;
        repeat (40) @(posedge clk);
        #1;
        check(n_got == DEP, "R8 kept words", n_got, DEP);
        compare_words("R8 kept words are the first ones", DEP);
        check(overflow == 1'b1, "R8 overflow sticky", int'(overflow), 1);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        @(posedge clk); #1;
        check(overflow == 1'b0, "R8 cleared by reset", int'(overflow), 0);

        // R9: back-to-back rows overrun a partly drained row
        // rows 1..4 keep only column 3; rows 5..7 keep columns 3..9
        send_frame(0, 1'b1);
        check(n_got == 4 + 3 * 7, "R9 words after row overrun", n_got, 25);
        check(overflow == 1'b1, "R9 overflow on row overrun", int'(overflow), 1);
        check(n_got > 4 && got[0] === {RW'(1), CW'(3), 5'd0} && got[4] === {RW'(5), CW'(3), 5'd0},
              "R9 surviving words", int'(got[4]), int'({RW'(5), CW'(3), 5'd0}));

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule